// File: doc/BRIEF.md
# Float-to-Int32 Truncating Converter

This block turns an already unpacked floating-point operand into a signed 32-bit integer. The operand arrives as a two-bit class, a sign bit, a signed unbiased exponent and a mantissa whose most significant bit is the explicit leading one. Its value is `mant × 2^(exp − (MANT_W − 1))`. The conversion always drops the fraction toward zero, whatever rounding mode the rest of the arithmetic unit uses. The block reports whether any fraction bit was lost (inexact) and whether the operand could not be represented (operand error).

Out-of-range operands saturate. Positive operands go to the largest positive integer and negative operands go to the most negative one. The limit depends on the sign, so −2^31 converts cleanly while +2^31 saturates. Infinities and NaNs take the same saturating path. The block has one register stage: an operand presented with `in_valid` in one cycle appears on the outputs in the next.

Top module: `f2i_trunc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `out_valid`, `out_int`, `out_inexact` and `out_operr` to 0.
- R2: `out_valid` is `in_valid` delayed by one clock. The outputs keep their values in every cycle after a cycle with `in_valid` low.
- R3: The class encoding is 0 = zero, 1 = number, 2 = infinity and 3 = NaN. A zero-class operand of either sign yields 0 with both flags clear.
- R4: For a number with exponent 0 to 31, the result is the magnitude truncated toward zero. A negative result is given as the two's complement of that magnitude.
- R5: For a number that does not overflow, `out_inexact` is 1 exactly when some mantissa bit below the binary point is 1, and `out_operr` is 0.
- R6: A number with exponent 32 or more, read as a signed value, overflows.
- R7: The overflow test is applied after truncation, against 2^31 plus the sign. A truncated magnitude of 2^31 overflows when positive. When negative it is accepted and gives 0x80000000.
- R8: Infinity and NaN operands overflow, whatever their sign.
- R9: On overflow the result is 0x7FFFFFFF for a positive operand and 0x80000000 for a negative one. `out_operr` is 1 and `out_inexact` is 0.
- R10: A number with a negative exponent, down to the most negative exponent value, yields 0 with `out_inexact` set and `out_operr` clear. No separate underflow indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 2 | Operand class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | 16 | Unbiased exponent, two's complement |
| in_mant | input | 64 | Mantissa, leading one in bit 63 |
| out_valid | output | 1 | Result present this cycle |
| out_int | output | 32 | Signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded |
| out_operr | output | 1 | Operand out of range, result saturated |

## Verification
Several behaviours are checked by assertions on every cycle:
- the one-cycle valid pipeline and the holding of outputs when idle;
- the mutual exclusion of the two flags;
- saturation values whenever the operand error is raised;
- the handling of the zero class, non-numbers, exponents of 32 and above, and negative exponents.

The exact truncated values, the inexact decision from the discarded bits and the sign-dependent limit at 2^31 can only be shown by the bench's scenarios. Those scenarios compare results against values worked out from the operand's value.

// File: rtl/f2i_pkg.sv
// Shared types for the float-to-integer converter.
// Assumes the two-bit class code is produced by an upstream unpacker.
package f2i_pkg;
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } f2i_class_e;
endpackage

// File: rtl/f2i_align.sv
// Aligns the mantissa to the integer binary point.
// Produces the truncated magnitude and a sticky bit for the discarded fraction.
// Assumes MANT_W > INT_W. The leading one sits at bit MANT_W-1.
// A negative exponent discards the whole mantissa.
module f2i_align #(
    parameter int MANT_W = 64,
    parameter int EXP_W  = 16,
    parameter int INT_W  = 32
) (
    input  logic [MANT_W-1:0]       mant,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [INT_W-1:0]        mag,
    output logic                    sticky,
    output logic                    exp_big
);
    localparam int SH_W    = $clog2(MANT_W) + 1;
    localparam int LOG_INT = $clog2(INT_W);

    logic              exp_neg;
    logic [SH_W-1:0]   sh;
    logic [MANT_W-1:0] shifted;
    logic [MANT_W-1:0] lost_mask;

    // Classify the exponent range and form the right-shift amount.
    always_comb begin
        exp_neg   = exp_in[EXP_W-1];
        exp_big   = !exp_neg && (exp_in >= $signed(EXP_W'(INT_W)));
        sh        = SH_W'(MANT_W - 1) - SH_W'(exp_in[LOG_INT-1:0]);
        shifted   = mant >> sh;
        lost_mask = ~({MANT_W{1'b1}} << sh);
    end

    // Select the magnitude and sticky bit for the exponent range.
    always_comb begin
        if (exp_neg) begin
            mag    = '0;
            sticky = |mant;
        end else if (exp_big) begin
            mag    = '0;
            sticky = 1'b0;
        end else begin
            mag    = shifted[INT_W-1:0];
            sticky = |(mant & lost_mask);
        end
    end
endmodule

// File: rtl/f2i_range.sv
// Applies the sign-dependent range test, saturation and negation.
// Assumes mag is already truncated toward zero.
module f2i_range
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  f2i_class_e       cls,
    input  logic             sign,
    input  logic             exp_big,
    input  logic [INT_W-1:0] mag,
    input  logic             sticky,
    output logic [INT_W-1:0] res,
    output logic             inexact,
    output logic             operr
);
    localparam logic [INT_W:0]   LIMIT = (INT_W+1)'(1) << (INT_W - 1);
    localparam logic [INT_W-1:0] MAXP  = {1'b0, {(INT_W-1){1'b1}}};

    logic             num_ovf;
    logic [INT_W-1:0] sat;

    // Range test after truncation; the limit grows by one for negatives.
    always_comb begin
        num_ovf = exp_big || ({1'b0, mag} >= (LIMIT + (INT_W+1)'(sign)));
        sat     = MAXP + INT_W'(sign);
    end

    // Pick the result and flags by operand class.
    always_comb begin
        res     = '0;
        inexact = 1'b0;
        operr   = 1'b0;
        case (cls)
            CLS_ZERO: ;
            CLS_NUM: begin
                if (num_ovf) begin
                    res   = sat;
                    operr = 1'b1;
                end else begin
                    res     = sign ? (~mag + INT_W'(1)) : mag;
                    inexact = sticky;
                end
            end
            default: begin
                res   = sat;
                operr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/f2i_trunc.sv
// Float-to-signed-integer converter that truncates toward zero.
// One register stage. Outputs hold while no operand is presented.
// Assumes an unpacked operand with the leading mantissa one explicit.
module f2i_trunc
    import f2i_pkg::*;
#(
    parameter int MANT_W = 64,
    parameter int EXP_W  = 16,
    parameter int INT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_class,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_int,
    output logic              out_inexact,
    output logic              out_operr
);
    logic [INT_W-1:0] mag;
    logic             sticky;
    logic             exp_big;
    logic [INT_W-1:0] res;
    logic             inexact;
    logic             operr;

    f2i_align #(.MANT_W(MANT_W), .EXP_W(EXP_W), .INT_W(INT_W)) i_align (
        .mant    (in_mant),
        .exp_in  ($signed(in_exp)),
        .mag     (mag),
        .sticky  (sticky),
        .exp_big (exp_big)
    );

    f2i_range #(.INT_W(INT_W)) i_range (
        .cls     (f2i_class_e'(in_class)),
        .sign    (in_sign),
        .exp_big (exp_big),
        .mag     (mag),
        .sticky  (sticky),
        .res     (res),
        .inexact (inexact),
        .operr   (operr)
    );

    // Output register: capture a result on each valid operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_inexact <= 1'b0;
            out_operr   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_int     <= res;
                out_inexact <= inexact;
                out_operr   <= operr;
            end
        end
    end
endmodule

// File: rtl/f2i_trunc_chk.sv
// Checker for f2i_trunc: port-level properties, bound to the top module.
module f2i_trunc_chk #(
    parameter int EXP_W = 16,
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_class,
    input logic [EXP_W-1:0] in_exp,
    input logic             out_valid,
    input logic [INT_W-1:0] out_int,
    input logic             out_inexact,
    input logic             out_operr
);
    localparam logic [INT_W-1:0] MAXP = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MAXN = {1'b1, {(INT_W-1){1'b0}}};

    // R2
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_int) && $stable(out_operr)
                       && $stable(out_inexact)));
    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_operr && out_inexact));
    // R9
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_operr |-> (out_int == MAXP || out_int == MAXN));
    // R3
    zero_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd0) |=>
        (out_int == '0 && !out_inexact && !out_operr));
    // R8
    nonnum_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class[1]) |=> out_operr);
    // R6
    big_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd1 && $signed(in_exp) >= $signed(EXP_W'(INT_W)))
        |=> out_operr);
    // R10
    neg_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd1 && in_exp[EXP_W-1]) |=>
        (out_int == '0 && out_inexact && !out_operr));
endmodule

bind f2i_trunc f2i_trunc_chk #(.EXP_W(EXP_W), .INT_W(INT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_class    (in_class),
    .in_exp      (in_exp),
    .out_valid   (out_valid),
    .out_int     (out_int),
    .out_inexact (out_inexact),
    .out_operr   (out_operr)
);

// File: tb/test_f2i_trunc.sv
`timescale 1ns/1ps
module test_f2i_trunc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = 2'd0;
    logic        in_sign = 1'b0;
    logic [15:0] in_exp = '0;
    logic [63:0] in_mant = '0;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_inexact;
    logic        out_operr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    f2i_trunc i_f2i_trunc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .out_valid(out_valid), .out_int(out_int),
        .out_inexact(out_inexact), .out_operr(out_operr)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Present one operand, then sample the registered result one cycle later.
    task automatic drive(input logic [1:0] c, input logic s, input int e, input logic [63:0] m);
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_sign = s; in_exp = 16'(e); in_mant = m;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] r, input logic ix, input logic op);
        chk({req, " value"}, out_int, r);
        chk({req, " inexact"}, 32'(out_inexact), 32'(ix));
        chk({req, " operr"}, 32'(out_operr), 32'(op));
    endtask

    task automatic t_reset;   // R1
        chk("R1 valid", 32'(out_valid), 0);
        expect_out("R1", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_zero;    // R3
        drive(2'd0, 1'b1, 5, 64'h8000_0000_0000_0000);
        chk("R2 valid", 32'(out_valid), 1);
        expect_out("R3 neg zero", 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_trunc;   // R4 R5
        drive(2'd1, 1'b0, 2, 64'hA000_0000_0000_0000);
        expect_out("R4 exact 5", 32'd5, 1'b0, 1'b0);
        drive(2'd1, 1'b0, 0, 64'hC000_0000_0000_0000);
        expect_out("R5 1.5", 32'd1, 1'b1, 1'b0);
        drive(2'd1, 1'b1, 1, 64'hB000_0000_0000_0000);
        expect_out("R4 -2.75", 32'hFFFF_FFFE, 1'b1, 1'b0);
        drive(2'd1, 1'b0, 30, 64'hFFFF_FFFF_8000_0000);
        expect_out("R5 max frac", 32'h7FFF_FFFF, 1'b1, 1'b0);
    endtask

    task automatic t_hold;    // R2
        repeat (3) @(negedge clk);
        chk("R2 idle valid", 32'(out_valid), 0);
        expect_out("R2 hold", 32'h7FFF_FFFF, 1'b1, 1'b0);
    endtask

    task automatic t_limit;   // R7 R9
        drive(2'd1, 1'b0, 31, 64'h8000_0000_0000_0000);
        expect_out("R7 +2^31", 32'h7FFF_FFFF, 1'b0, 1'b1);
        drive(2'd1, 1'b1, 31, 64'h8000_0000_0000_0000);
        expect_out("R7 -2^31", 32'h8000_0000, 1'b0, 1'b0);
        drive(2'd1, 1'b1, 31, 64'h8000_0000_8000_0000);
        expect_out("R7 -2^31-0.5", 32'h8000_0000, 1'b1, 1'b0);
        drive(2'd1, 1'b1, 31, 64'h8000_0001_0000_0000);
        expect_out("R9 -2^31-1", 32'h8000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_bigexp;  // R6
        drive(2'd1, 1'b0, 32, 64'h8000_0000_0000_0001);
        expect_out("R6 exp32", 32'h7FFF_FFFF, 1'b0, 1'b1);
        drive(2'd1, 1'b1, 32767, 64'hC000_0000_0000_0000);
        expect_out("R6 exp max", 32'h8000_0000, 1'b0, 1'b1);
    endtask

    task automatic t_nonnum;  // R8
        drive(2'd2, 1'b0, 0, 64'h8000_0000_0000_0000);
        expect_out("R8 +inf", 32'h7FFF_FFFF, 1'b0, 1'b1);
        drive(2'd2, 1'b1, 0, 64'h8000_0000_0000_0000);
        expect_out("R8 -inf", 32'h8000_0000, 1'b0, 1'b1);
        drive(2'd3, 1'b0, 3, 64'hC000_0000_0000_0000);
        expect_out("R8 nan", 32'h7FFF_FFFF, 1'b0, 1'b1);
    endtask

    task automatic t_small;   // R10
        drive(2'd1, 1'b0, -1, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_out("R10 exp-1", 32'h0, 1'b1, 1'b0);
        drive(2'd1, 1'b1, -65, 64'h8000_0000_0000_0000);
        expect_out("R10 exp-65", 32'h0, 1'b1, 1'b0);
        drive(2'd1, 1'b1, -32768, 64'h8000_0000_0000_0000);
        expect_out("R10 exp min", 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_sweep;   // R4 R5 R6 R7 R10 against a value-based model
        for (int e = -3; e <= 34; e++) begin
            for (int s = 0; s < 2; s++) begin
                logic [63:0] m;
                logic [63:0] whole;
                logic [63:0] frac;
                logic [31:0] r;
                logic ix;
                logic op;
                m = 64'hD5A3_96C1_0000_0001 ^ (64'(e) << 20);
                m[63] = 1'b1;
                r = 0; ix = 0; op = 0;
                if (e >= 32) op = 1;
                else if (e < 0) ix = 1;
                else begin
                    whole = m >> (63 - e);
                    frac = m << (e + 1);
                    if (whole >= 64'h8000_0000 + 64'(s)) op = 1;
                    else begin
                        ix = (frac != 0);
                        r = (s != 0) ? -whole[31:0] : whole[31:0];
                    end
                end
                if (op) r = (s != 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
                drive(2'd1, s[0], e, m);
                expect_out("R4 sweep", r, ix, op);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_zero();
        t_trunc();
        t_hold();
        t_limit();
        t_bigexp();
        t_nonnum();
        t_small();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule